// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host reach an external asynchronous static RAM of 64K words by 16 bits. The host raises a request strobe together with a read/write flag, a word address, write data and a two-bit byte-enable mask. The controller latches the request and produces the active-low chip-enable, output-enable, write-enable and two byte-select strobes with timed wait states. It drives the shared data bus through a separate output-enable, and reports completion with a one-cycle done pulse. On a read the returned word is held in a register.

Every wait length is a parameter given in clock cycles. The integrator chooses each one from the clock period and the speed grade of the memory. The read strobe is held for `RD_WAIT` cycles. A write has three phases, each with its own count: an address setup phase with chip enable low, a write-enable pulse, and a hold phase.

The write ends on the rising edge of write enable. Address and data stay fixed across that edge. When a write follows a read, the controller adds one idle cycle first, so the memory has let go of the bus before the controller drives it. A request that arrives while an operation is in progress is ignored.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both byte selects are high. The bus drive enable and done are low, and the read data register is zero.
- R2: A read request is accepted in idle. From the next cycle, chip enable and output enable are low and write enable is high, with the request address on the memory address pins, for `RD_WAIT` cycles. On the edge that ends this window, `mem_dq_in` is captured into `rd_data`, done goes high and the strobes return high.
- R3: Byte-enable bit 0 drives the lower select `mem_lb_n`, which covers data bits 7:0. Byte-enable bit 1 drives the upper select `mem_ub_n`, which covers bits 15:8. A select is low only while chip enable is low and its enable bit is 1, so a mask of 00 leaves both selects high.
- R4: A write holds chip enable low with write enable high for `WR_SETUP` cycles. Write enable is then low for `WR_PULSE` cycles. Write enable then returns high with chip enable still low for `WR_HOLD` cycles. Chip enable rises and done pulses on the edge that ends the hold. Output enable stays high for the whole write.
- R5: The bus drive enable is high exactly while write enable is low and during the hold cycles. During that time `mem_dq_out` equals the request's write data, and the address does not change across the rising edge of write enable.
- R6: Output enable is never low while the bus drive enable is high.
- R7: A write whose previous completed operation was a read waits one extra cycle, with all strobes high, before chip enable falls. A write that follows a write waits no extra cycle.
- R8: A request that arrives while an operation is in progress is ignored. It does not change the address pins, it is not executed later, and it produces no done pulse.
- R9: Done lasts exactly one cycle. `rd_data` changes only on read completion, so writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Registered read data |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | 16 | Data driven onto the shared bus |
| mem_dq_oe | output | 1 | Drive enable for the shared bus |
| mem_dq_in | input | 16 | Data read from the shared bus |

## Verification
Reads are issued with each of the masks 11, 01 and 10, so a swapped or inverted byte-select mapping shows up. A write with mask 00 confirms that both selects stay high. A write is issued right after a read and again right after a write, which shows whether the turnaround cycle is added only where it belongs. A write request is held high during a read's wait window to confirm it is neither taken nor queued. Each operation is followed cycle by cycle, so an off-by-one in any wait count moves a strobe edge or the done pulse and is caught.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_WRITE_HOLD,
    ST_TURNAROUND
  } seq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_port_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2,
  parameter int WR_HOLD  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic load,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic drv_en,
  output logic done
);
  localparam int MAXC = max4(RD_WAIT, WR_SETUP, WR_PULSE, WR_HOLD);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LD = CW'(RD_WAIT - 1);
  localparam logic [CW-1:0] WS_LD = CW'(WR_SETUP - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WR_PULSE - 1);
  localparam logic [CW-1:0] WH_LD = CW'(WR_HOLD - 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;
  logic            rd_last;
  logic            cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign load     = (state == ST_IDLE) && req_valid;
  assign capture  = (state == ST_READ_WAIT) && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rd_last <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      drv_en  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_write) begin
              state <= ST_READ_WAIT;
              cnt   <= RD_LD;
              ce_n  <= 1'b0;
              oe_n  <= 1'b0;
            end else if (rd_last) begin
              state <= ST_TURNAROUND;
            end else begin
              state <= ST_WRITE_SETUP;
              cnt   <= WS_LD;
              ce_n  <= 1'b0;
            end
          end
        end
        ST_TURNAROUND: begin
          state   <= ST_WRITE_SETUP;
          cnt     <= WS_LD;
          ce_n    <= 1'b0;
          rd_last <= 1'b0;
        end
        ST_READ_WAIT: begin
          if (cnt_zero) begin
            state   <= ST_IDLE;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            done    <= 1'b1;
            rd_last <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE_SETUP: begin
          if (cnt_zero) begin
            state  <= ST_WRITE_PULSE;
            cnt    <= WP_LD;
            we_n   <= 1'b0;
            drv_en <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE_PULSE: begin
          if (cnt_zero) begin
            state <= ST_WRITE_HOLD;
            cnt   <= WH_LD;
            we_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE_HOLD: begin
          if (cnt_zero) begin
            state  <= ST_IDLE;
            ce_n   <= 1'b1;
            drv_en <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [BW-1:0] be_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int BW = 2
) (
  input  logic          ce_n,
  input  logic [BW-1:0] be_q,
  output logic [BW-1:0] sel_n
);
  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign sel_n[i] = ce_n | ~be_q[i];
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int RD_WAIT  = 3,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2,
  parameter int WR_HOLD  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int LANES = DW / 8;

  logic             load;
  logic             capture;
  logic [LANES-1:0] be_q;
  logic [LANES-1:0] sel_n;

  sram_seq_fsm #(
    .RD_WAIT(RD_WAIT), .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE), .WR_HOLD(WR_HOLD)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .load(load), .capture(capture),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .drv_en(mem_dq_oe), .done(done)
  );

  sram_data_path #(.AW(AW), .DW(DW), .BW(LANES)) u_dp (
    .clk(clk), .rst(rst), .load(load), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be[LANES-1:0]),
    .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .be_q(be_q), .rdata_q(rd_data)
  );

  sram_lane_sel #(.BW(LANES)) u_lanes (
    .ce_n(mem_ce_n), .be_q(be_q), .sel_n(sel_n)
  );

  assign mem_lb_n = sel_n[0];
  assign mem_ub_n = sel_n[LANES-1];
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_lanes_idle_r3: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_ub_n && mem_lb_n));

  p_we_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  p_we_rise_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out)));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;
  localparam int RD = 3;
  localparam int WS = 1;
  localparam int WP = 2;
  localparam int WH = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        done;
  logic [15:0] rd_data;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_port_ctrl #(.RD_WAIT(RD), .WR_SETUP(WS), .WR_PULSE(WP), .WR_HOLD(WH)) i_sram_port_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, done};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(strobes() == 7'b1111100, "R1 strobes after reset", strobes(), 7'b1111100);
    check(rd_data == 16'h0, "R1 rd_data after reset", rd_data, 16'h0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Read; when poke is set a write request is held during the wait window (R8)
  task automatic t_read(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d, input bit poke);
    logic [6:0] exp_s;
    logic [15:0] old;
    old = rd_data;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; mem_dq_in = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = 16'hDEAD; req_be = 2'b11;
    end
    exp_s = {1'b0, 1'b0, 1'b1, ~be[1], ~be[0], 1'b0, 1'b0};
    for (int k = 0; k < RD; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == RD - 1) req_valid = 1'b0;
      check(strobes() == exp_s, "R2/R3 read strobes and lanes", strobes(), exp_s);
      check(mem_addr == a, poke ? "R8 address held during busy" : "R2 read address", mem_addr, a);
      check(rd_data == old, "R9 rd_data stable in read wait", rd_data, old);
    end
    @(negedge clk);
    check(done && rd_data == d, "R2 read capture and done", {done, rd_data}, {1'b1, d});
    check(strobes() == 7'b1111101, "R2 strobes released at done", strobes(), 7'b1111101);
    mem_dq_in = ~d;
    @(negedge clk);
    check(!done, "R9 done single cycle", done, 1'b0);
    check(rd_data == d, "R9 rd_data held after read", rd_data, d);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        check(mem_ce_n && !done, "R8 busy request not executed", {mem_ce_n, done}, 2'b10);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be, input bit ta);
    logic [15:0] old;
    logic [6:0] exp_s;
    old = rd_data;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ta) begin
      check(strobes() == 7'b1111100, "R7 turnaround cycle idle", strobes(), 7'b1111100);
      @(negedge clk);
    end
    for (int k = 0; k < WS; k++) begin
      if (k > 0) @(negedge clk);
      exp_s = {1'b0, 1'b1, 1'b1, ~be[1], ~be[0], 1'b0, 1'b0};
      check(strobes() == exp_s, ta ? "R7/R4 setup after turnaround" : "R7/R4 setup no turnaround", strobes(), exp_s);
      check(mem_addr == a, "R4 write address", mem_addr, a);
    end
    for (int k = 0; k < WP; k++) begin
      @(negedge clk);
      exp_s = {1'b0, 1'b1, 1'b0, ~be[1], ~be[0], 1'b1, 1'b0};
      check(strobes() == exp_s, "R4/R5/R6 write pulse", strobes(), exp_s);
      check(mem_dq_out == d && mem_addr == a, "R5 data and address in pulse", {mem_dq_out, mem_addr}, {d, a});
    end
    for (int k = 0; k < WH; k++) begin
      @(negedge clk);
      exp_s = {1'b0, 1'b1, 1'b1, ~be[1], ~be[0], 1'b1, 1'b0};
      check(strobes() == exp_s, "R4/R5 write hold", strobes(), exp_s);
      check(mem_dq_out == d && mem_addr == a, "R5 data held after we rise", {mem_dq_out, mem_addr}, {d, a});
    end
    @(negedge clk);
    check(strobes() == 7'b1111101, "R4 write done", strobes(), 7'b1111101);
    check(rd_data == old, "R9 write leaves rd_data", rd_data, old);
    @(negedge clk);
    check(!done, "R9 done single cycle after write", done, 1'b0);
  endtask

  initial begin
    t_reset();
    t_read(16'h1234, 2'b11, 16'hA55A, 1'b0);
    t_read(16'h0001, 2'b01, 16'h00C3, 1'b0);
    t_read(16'hFFFF, 2'b10, 16'h7E00, 1'b0);
    t_write(16'h4321, 16'hBEEF, 2'b11, 1'b1);
    t_write(16'h8000, 16'h1357, 2'b10, 1'b0);
    t_write(16'h0F0F, 16'h2468, 2'b00, 1'b0);
    t_read(16'h2222, 2'b11, 16'h9999, 1'b1);
    t_write(16'h3333, 16'hCAFE, 2'b01, 1'b1);
    t_read(16'hABCD, 2'b11, 16'h0FF0, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule